// File: doc/BRIEF.md
# Byte-Serial Redundant Output Voter

This block takes 16-bit results from a primary generator and from up to two replica generators. Every source delivers each result as two consecutive byte transfers, each marked by its own valid strobe. Two enable inputs declare which replicas are present. The block reassembles the words. Once every active source has delivered a complete word, it compares the primary with the first replica and the first replica with the second.

The protection level follows the number of replicas. With no replica, the primary word passes through and nothing is checked. With one replica, a difference is reported as a detected fault; the surrounding regime controller uses that report to halt execution. With two replicas, the block outputs the value that at least two sources agree on. It raises an uncorrectable flag when all three words differ. The pairwise mismatch flags are returned to the controller in every mode, so it can act on them according to how many replicas it has built.

Top module: `serial_tmr_voter`

## Requirements
- R1: After reset `res_vld`, `res_word`, `mis_p_r1`, `mis_r1_r2` and `uncorr` are all 0.
- R2: A source sends the high byte (bits 15:8) first and the low byte (bits 7:0) second, each on a cycle where its valid strobe is high. Strobes from a replica that is not active are ignored.
- R3: A result is issued only when every active source has delivered both bytes of its current word. `res_vld` goes high for exactly one cycle, one clock after the edge that accepts the last outstanding low byte.
- R4: With no replica active, `res_word` equals the primary word and `mis_p_r1`, `mis_r1_r2` and `uncorr` are 0.
- R5: With only the first replica active, `mis_p_r1` is 1 exactly when the primary and first replica words differ. `mis_r1_r2` is 0 and `res_word` is the primary word.
- R6: With both replicas active, `mis_p_r1` flags primary≠replica1 and `mis_r1_r2` flags replica1≠replica2.
- R7: With both replicas active, `res_word` is the value shared by at least two of the three words.
- R8: With both replicas active and all three words different, `uncorr` is 1 and `res_word` is the primary word. Otherwise `uncorr` is 0.
- R9: A change on either enable input returns every source to expecting a high byte and discards partly or fully received words. No result is issued on that edge.
- R10: The second replica counts as active only while the first replica is also enabled.
- R11: `res_word` and the flags hold their values between result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_r1 | input | 1 | First replica present |
| en_r2 | input | 1 | Second replica present (needs en_r1) |
| p_vld | input | 1 | Primary byte valid |
| p_byte | input | 8 | Primary byte |
| r1_vld | input | 1 | First replica byte valid |
| r1_byte | input | 8 | First replica byte |
| r2_vld | input | 1 | Second replica byte valid |
| r2_byte | input | 8 | Second replica byte |
| res_vld | output | 1 | One-cycle pulse, new result |
| res_word | output | 16 | Voted or passed-through word |
| mis_p_r1 | output | 1 | Primary differs from first replica |
| mis_r1_r2 | output | 1 | First replica differs from second |
| uncorr | output | 1 | All three words differ |

## Verification
A high byte is captured at one edge and a low byte at a later edge. The edge after the last low byte raises `res_vld` together with the word and flags. When all sources send in lockstep, the result is therefore visible in the third cycle after the high bytes are presented. Inputs are driven on falling edges and outputs are read at the falling edge that follows the expected rising edge. The bench also reads `res_vld` one cycle before a result is due to catch early results, and one cycle after to confirm the single-cycle pulse. For staggered arrival and for enable changes, the bench reads at the cycle where a missing wait or a stale byte phase would have produced a premature result.

// File: rtl/serial_tmr_voter.sv
module serial_tmr_voter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_r1,
  input  logic        en_r2,
  input  logic        p_vld,
  input  logic [7:0]  p_byte,
  input  logic        r1_vld,
  input  logic [7:0]  r1_byte,
  input  logic        r2_vld,
  input  logic [7:0]  r2_byte,
  output logic        res_vld,
  output logic [15:0] res_word,
  output logic        mis_p_r1,
  output logic        mis_r1_r2,
  output logic        uncorr
);
  localparam int NSRC = 3;

  logic [NSRC-1:0] act, act_q, vld, phase, done;
  logic [7:0]      din [NSRC];
  logic [7:0]      hi  [NSRC];
  logic [15:0]     wd  [NSRC];
  logic            en_chg, ready, eq01, eq12, eq02;

  assign act    = {en_r1 & en_r2, en_r1, 1'b1};
  assign vld    = {r2_vld, r1_vld, p_vld};
  assign din[0] = p_byte;
  assign din[1] = r1_byte;
  assign din[2] = r2_byte;
  assign en_chg = act != act_q;
  assign ready  = !en_chg && (&(done | ~act));
  assign eq01   = wd[0] == wd[1];
  assign eq12   = wd[1] == wd[2];
  assign eq02   = wd[0] == wd[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 3'b001;
      phase <= '0;
      done  <= '0;
      for (int i = 0; i < NSRC; i++) begin
        hi[i] <= '0;
        wd[i] <= '0;
      end
    end else begin
      act_q <= act;
      for (int i = 0; i < NSRC; i++) begin
        if (en_chg) begin
          phase[i] <= 1'b0;
          done[i]  <= 1'b0;
        end else begin
          if (vld[i] && act[i]) begin
            if (!phase[i]) hi[i] <= din[i];
            else           wd[i] <= {hi[i], din[i]};
            phase[i] <= !phase[i];
          end
          done[i] <= (done[i] && !ready) || (vld[i] && act[i] && phase[i]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_word  <= '0;
      mis_p_r1  <= 1'b0;
      mis_r1_r2 <= 1'b0;
      uncorr    <= 1'b0;
    end else begin
      res_vld <= ready;
      if (ready) begin
        mis_p_r1  <= act[1] && !eq01;
        mis_r1_r2 <= act[2] && !eq12;
        uncorr    <= act[2] && !eq01 && !eq12 && !eq02;
        res_word  <= (act[2] && !eq01 && !eq02 && eq12) ? wd[1] : wd[0];
      end
    end
  end
endmodule

module serial_tmr_voter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_r1,
  input logic        en_r2,
  input logic        res_vld,
  input logic [15:0] res_word,
  input logic        mis_p_r1,
  input logic        mis_r1_r2,
  input logic        uncorr
);
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld); // R3
  AST_UNCORR_BOTH_MIS: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |-> (mis_p_r1 && mis_r1_r2)); // R8
  AST_R2MIS_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && mis_r1_r2) |-> $past(en_r1 && en_r2)); // R10
  AST_NOCOPY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !$past(en_r1)) |-> (!mis_p_r1 && !mis_r1_r2 && !uncorr)); // R4
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> ($stable(res_word) && $stable(mis_p_r1) && $stable(uncorr))); // R11
endmodule

bind serial_tmr_voter serial_tmr_voter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_r1(en_r1), .en_r2(en_r2),
  .res_vld(res_vld), .res_word(res_word), .mis_p_r1(mis_p_r1),
  .mis_r1_r2(mis_r1_r2), .uncorr(uncorr)
);

// File: tb/serial_tmr_voter_tb_top.sv
module serial_tmr_voter_tb_top;
  logic clk = 0, rst_n = 0, en_r1 = 0, en_r2 = 0;
  logic p_vld = 0, r1_vld = 0, r2_vld = 0;
  logic [7:0] p_byte = 0, r1_byte = 0, r2_byte = 0;
  logic res_vld, mis_p_r1, mis_r1_r2, uncorr;
  logic [15:0] res_word;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  serial_tmr_voter dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic [2:0] v, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    @(negedge clk);
    {r2_vld, r1_vld, p_vld} = v;
    p_byte = a; r1_byte = b; r2_byte = c;
  endtask

  task automatic set_en(input logic e1, input logic e2);
    @(negedge clk);
    en_r1 = e1; en_r2 = e2;
    drv(3'b000, 0, 0, 0);
  endtask

  task automatic send(input logic [2:0] v, input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    drv(v, a[15:8], b[15:8], c[15:8]);
    drv(v, a[7:0], b[7:0], c[7:0]);
    drv(3'b000, 0, 0, 0);
  endtask

  task automatic expect_res(input string tag, input logic [15:0] w, input logic m1, input logic m2, input logic u);
    @(negedge clk);
    chk({tag, " vld"}, res_vld, 1);
    chk({tag, " word"}, res_word, w);
    chk({tag, " mis_p_r1"}, mis_p_r1, m1);
    chk({tag, " mis_r1_r2"}, mis_r1_r2, m2);
    chk({tag, " uncorr"}, uncorr, u);
    @(negedge clk);
    chk({tag, " pulse end R3"}, res_vld, 0);
    chk({tag, " hold R11"}, res_word, w);
  endtask

  task automatic t_nocopy;
    set_en(0, 0);
    send(3'b111, 16'hA5C3, 16'h1111, 16'h2222);
    expect_res("R4 R2 passthrough", 16'hA5C3, 0, 0, 0);
  endtask

  task automatic t_onecopy;
    set_en(1, 0);
    send(3'b111, 16'h1234, 16'h1234, 16'hFFFF);
    expect_res("R5 equal", 16'h1234, 0, 0, 0);
    send(3'b011, 16'h1234, 16'h1235, 16'h0);
    expect_res("R5 differ", 16'h1234, 1, 0, 0);
  endtask

  task automatic t_twocopy;
    set_en(1, 1);
    send(3'b111, 16'h5555, 16'h5555, 16'h5555);
    expect_res("R6 R7 all equal", 16'h5555, 0, 0, 0);
    send(3'b111, 16'h0BAD, 16'h600D, 16'h600D);
    expect_res("R7 primary bad", 16'h600D, 1, 0, 0);
    send(3'b111, 16'h600D, 16'h600D, 16'h0BAD);
    expect_res("R6 replica2 bad", 16'h600D, 0, 1, 0);
    send(3'b111, 16'h600D, 16'h0BAD, 16'h600D);
    expect_res("R7 replica1 bad", 16'h600D, 1, 1, 0);
    send(3'b111, 16'h0001, 16'h0002, 16'h0003);
    expect_res("R8 all differ", 16'h0001, 1, 1, 1);
  endtask

  task automatic t_stagger;
    set_en(1, 1);
    drv(3'b011, 8'h3C, 8'h3C, 0);
    drv(3'b011, 8'h77, 8'h77, 0);
    drv(3'b000, 0, 0, 0);
    drv(3'b100, 0, 0, 8'h3C);
    chk("R3 no early result", res_vld, 0);
    drv(3'b100, 0, 0, 8'h77);
    drv(3'b000, 0, 0, 0);
    expect_res("R3 staggered", 16'h3C77, 0, 0, 0);
  endtask

  task automatic t_enchange;
    set_en(1, 1);
    drv(3'b111, 8'hEE, 8'hEE, 8'hEE);
    @(negedge clk);
    en_r2 = 0; {r2_vld, r1_vld, p_vld} = 0;
    drv(3'b011, 8'h4A, 8'h4A, 0);
    drv(3'b011, 8'h21, 8'h21, 0);
    drv(3'b000, 0, 0, 0);
    chk("R9 stale phase", res_vld, 0);
    expect_res("R9 after change", 16'h4A21, 0, 0, 0);
  endtask

  task automatic t_r2_alone;
    set_en(0, 1);
    send(3'b101, 16'h7001, 16'h0, 16'h7002);
    expect_res("R10 r2 without r1", 16'h7001, 0, 0, 0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 vld", res_vld, 0);
    chk("R1 word", res_word, 0);
    chk("R1 flags", {mis_p_r1, mis_r1_r2, uncorr}, 0);
    rst_n = 1;
    t_nocopy();
    t_onecopy();
    t_twocopy();
    t_stagger();
    t_enchange();
    t_r2_alone();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule